// File: doc/BRIEF.md
# FM0 Receive Clock Recovery DPLL

This block recovers bit timing and data from a serial line carrying FM0 (bi-phase space) code. The line changes level at every bit-cell boundary. A further change halfway through the cell means the bit is 0, and no change there means the bit is 1. The block is clocked by a sampling clock at sixteen times the bit rate; for example, 3.6864 MHz samples a 230.4 kbit/s line. It delivers a recovered receive clock, one decoded bit per cell with a one-cycle strobe, and a lock flag. The downstream serial receiver runs from these outputs.

A four-bit phase counter runs through 16 counts per cell, and count 0 is the ideal boundary phase. After reset the loop is off (`ST_OFF`) and ignores the line. A search command moves it to `ST_HUNT` (transition *arm*). In `ST_HUNT` the first line edge loads the counter as if that edge were a boundary, and the loop moves to `ST_TRACK` (transition *acquire*). While tracking, each line edge is classified by the counter value:
- counts 4 to 11 form the mid-cell window;
- counts 12 to 15 and 0 to 3 form the boundary window.

A boundary edge far from count 0 nudges the counter by one count. When two boundary windows in a row have no edge, the loop returns to `ST_HUNT` (transition *lose*). A search command while tracking also returns to `ST_HUNT` (transition *rehunt*). A disable command sends any state to `ST_OFF` (transition *shutdown*).

Top module: `fm0_dpll`

## Requirements
- R1: After reset, `locked`, `bit_valid` and `rclk` are all 0.
- R2: In `ST_OFF`, line edges have no effect: `locked` stays 0 and `bit_valid` never pulses.
- R3: In `ST_HUNT`, `locked` stays 0 while the line is quiet. The first sampled edge sets `locked` on the next cycle, and that edge counts as phase 0 of a cell.
- R4: At the end of each cell the block presents `bit_data` = 1 if no edge fell in counts 4 to 11 of that cell, and 0 if one did.
- R5: `bit_valid` is a one-cycle pulse, once per cell. After a lock edge sampled at cycle c, the first pulse is visible after edge c+15. With boundaries every 16 samples, pulses are 16 cycles apart.
- R6: A boundary edge sampled at count 12, 13 or 14 (early) makes the counter skip one count. A boundary edge at count 2 or 3 (late) holds the counter for one cycle. For example, an edge at count 14 ends the cell one cycle early, and an edge at count 2 makes the next cell 17 cycles long.
- R7: A boundary edge at count 15, 0 or 1 causes no phase adjustment.
- R8: One boundary window without an edge keeps lock. A second consecutive empty window drops `locked` at count 8 of that cell.
- R9: `disable_cmd` moves any state to `ST_OFF` on the next cycle and has priority over `search_cmd`.
- R10: `search_cmd` while locked drops `locked` on the next cycle. The next edge then relocks.
- R11: `rclk` is 1 for counts 0 to 7 and 0 for counts 8 to 15 while locked, and 0 whenever not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 16 times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Raw FM0 receive line |
| search_cmd | input | 1 | Enter search mode (one-cycle command) |
| disable_cmd | input | 1 | Stop the loop (one-cycle command) |
| rclk | output | 1 | Recovered receive clock, high during the first half of the cell |
| bit_data | output | 1 | Decoded bit of the last finished cell |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_data` |
| locked | output | 1 | Loop is tracking |

## Verification
The bench sends a boundary two counts early and one two counts late, and measures the spacing between strobes. A loop that corrects in the wrong direction, or not at all, shifts these pulses by a cycle. A loop that corrects by more than one count also shifts them. Boundaries only one count off must leave the spacing at 16, which catches a design that overreacts to jitter. The bench ends a frame and checks that lock survives the first missing boundary and falls at the second, which catches an off-by-one in the miss counter. It also issues disable and search together, and toggles the line while the loop is off, to expose a wrong command priority or edges that leak through.

// File: rtl/fm0_dpll_pkg.sv
package fm0_dpll_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HUNT  = 2'd1,
        ST_TRACK = 2'd2
    } dpll_state_e;
endpackage

// File: rtl/fm0_edge_det.sv
module fm0_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line_i;
    end

    assign edge_o = line_i ^ prev_q;
endmodule

// File: rtl/fm0_phase_ctr.sv
module fm0_phase_ctr #(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          run_i,
    input  logic          edge_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    localparam int QTR = OSR / 4;

    logic        early, late;
    logic [1:0]  step;
    logic [CW:0] sum;

    always_comb begin
        early = edge_i && (cnt_o >= CW'(OSR - QTR)) && (cnt_o <= CW'(OSR - 2));
        late  = edge_i && (cnt_o >= CW'(2)) && (cnt_o <= CW'(QTR - 1));
        if (early)     step = 2'd2;
        else if (late) step = 2'd0;
        else           step = 2'd1;
        sum    = {1'b0, cnt_o} + {{(CW-1){1'b0}}, step};
        wrap_o = run_i && sum[CW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_o <= '0;
        else if (load_i) cnt_o <= CW'(1);
        else if (run_i)  cnt_o <= sum[CW-1:0];
        else             cnt_o <= '0;
    end

    // R6: a running counter never moves by more than two counts
    assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i) |=> (CW'(cnt_o - $past(cnt_o)) <= CW'(2)));
    // R7: with no edge the counter advances by exactly one
    assert_quiet_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && !edge_i) |=> (cnt_o == CW'($past(cnt_o) + CW'(1))));
endmodule

// File: rtl/fm0_cell_dec.sv
module fm0_cell_dec #(
    parameter int OSR        = 16,
    parameter int CW         = $clog2(OSR),
    parameter int MISS_LIMIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          run_i,
    input  logic          edge_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          wrap_i,
    output logic          bit_o,
    output logic          valid_o,
    output logic          drop_o
);
    localparam int QTR = OSR / 4;
    localparam int MW  = $clog2(MISS_LIMIT + 1);

    logic          mid_seen, bnd_hit, mid_win, chk_pt;
    logic [MW-1:0] miss_q;

    always_comb begin
        mid_win = (cnt_i >= CW'(QTR)) && (cnt_i <= CW'(OSR - QTR - 1));
        chk_pt  = run_i && (cnt_i == CW'(OSR / 2));
        drop_o  = chk_pt && !bnd_hit && (miss_q == MW'(MISS_LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_seen <= 1'b0;
            bnd_hit  <= 1'b0;
            miss_q   <= '0;
            valid_o  <= 1'b0;
            bit_o    <= 1'b0;
        end else if (start_i) begin
            mid_seen <= 1'b0;
            bnd_hit  <= 1'b1;
            miss_q   <= '0;
            valid_o  <= 1'b0;
        end else if (!run_i) begin
            mid_seen <= 1'b0;
            bnd_hit  <= 1'b0;
            miss_q   <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= wrap_i;
            if (wrap_i) bit_o <= ~mid_seen;
            if (wrap_i)                 mid_seen <= 1'b0;
            else if (edge_i && mid_win) mid_seen <= 1'b1;
            if (chk_pt) begin
                bnd_hit <= 1'b0;
                miss_q  <= bnd_hit ? '0 : miss_q + MW'(1);
            end else if (edge_i && !mid_win) begin
                bnd_hit <= 1'b1;
            end
        end
    end

    // R5: the strobe never lasts two cycles
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/fm0_dpll.sv
module fm0_dpll
    import fm0_dpll_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int MISS_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic search_cmd,
    input  logic disable_cmd,
    output logic rclk,
    output logic bit_data,
    output logic bit_valid,
    output logic locked
);
    localparam int CW = $clog2(OSR);

    dpll_state_e   state, nxt;
    logic          line_edge, load, run, wrap, drop;
    logic [CW-1:0] cnt;

    fm0_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .line_i(rx_line), .edge_o(line_edge)
    );

    fm0_phase_ctr #(.OSR(OSR), .CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(load), .run_i(run),
        .edge_i(line_edge), .cnt_o(cnt), .wrap_o(wrap)
    );

    fm0_cell_dec #(.OSR(OSR), .CW(CW), .MISS_LIMIT(MISS_LIMIT)) u_dec (
        .clk(clk), .rst_n(rst_n), .start_i(load), .run_i(run),
        .edge_i(line_edge), .cnt_i(cnt), .wrap_i(wrap),
        .bit_o(bit_data), .valid_o(bit_valid), .drop_o(drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (search_cmd) nxt = ST_HUNT;
            ST_HUNT:  if (line_edge && !search_cmd) nxt = ST_TRACK;
            ST_TRACK: if (search_cmd || drop) nxt = ST_HUNT;
            default:  nxt = ST_OFF;
        endcase
        if (disable_cmd) nxt = ST_OFF;
    end

    always_comb begin
        locked = (state == ST_TRACK);
        load   = (state == ST_HUNT) && line_edge && !search_cmd && !disable_cmd;
        run    = locked && !search_cmd && !disable_cmd;
        rclk   = locked && (cnt < CW'(OSR / 2));
    end

    // R9: disable wins over everything
    assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disable_cmd |=> (!locked && !bit_valid));
    // R3: an accepted search edge yields lock in the first half of a cell
    assert_lock_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (locked && rclk));
    // R10: a search command while tracking releases lock
    assert_rehunt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (search_cmd && locked) |=> !locked);
    // R8: a lost-lock decision takes effect on the next cycle
    assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !locked);
    // R11: no recovered clock while not tracking
    assert_rclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !rclk);
    // R2: strobes come only from cells timed while tracking
    assert_valid_from_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(locked));
endmodule

// File: tb/tb_fm0_dpll.sv
`timescale 1ns/1ps
module tb_fm0_dpll;
    logic clk = 1'b0;
    logic rst_n, rx_line, search_cmd, disable_cmd;
    logic rclk, bit_data, bit_valid, locked;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int vn = 0;
    int vcyc [64];
    logic vbit [64];
    bit done = 1'b0;

    // table entries: bit value in [5], cell length in samples in [4:0]
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        {1'b1, 5'd16}, {1'b0, 5'd16}, {1'b0, 5'd16}, {1'b1, 5'd16},
        {1'b1, 5'd17}, {1'b0, 5'd15}, {1'b1, 5'd16}, {1'b0, 5'd16},
        {1'b1, 5'd16}, {1'b1, 5'd16}, {1'b0, 5'd16}, {1'b1, 5'd16}
    };

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (bit_valid && vn < 64) begin
            vcyc[vn] = cyc;
            vbit[vn] = bit_data;
            vn = vn + 1;
        end
    end

    fm0_dpll dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .search_cmd(search_cmd),
        .disable_cmd(disable_cmd), .rclk(rclk), .bit_data(bit_data),
        .bit_valid(bit_valid), .locked(locked)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_cell(input logic b, input int len, output int c);
        rx_line = ~rx_line;
        c = cyc + 1;
        repeat (len / 2) @(negedge clk);
        if (!b) rx_line = ~rx_line;
        repeat (len - len / 2) @(negedge clk);
    endtask

    task automatic arm();
        disable_cmd = 1'b1;
        @(negedge clk);
        disable_cmd = 1'b0;
        search_cmd = 1'b1;
        @(negedge clk);
        search_cmd = 1'b0;
    endtask

    task automatic adj_run(input int l0, input int ef, input int eg, input string req);
        int c0, cx;
        arm();
        vn = 0;
        drive_cell(1'b1, l0, c0);
        drive_cell(1'b1, 16, cx);
        drive_cell(1'b1, 16, cx);
        repeat (2) @(negedge clk);
        chk(vn >= 2, req, vn, 2);
        chk(vcyc[0] - c0 == ef, req, vcyc[0] - c0, ef);
        chk(vcyc[1] - vcyc[0] == eg, req, vcyc[1] - vcyc[0], eg);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int c, cfirst, cnt_before;
        rst_n = 1'b0; rx_line = 1'b0; search_cmd = 1'b0; disable_cmd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(locked == 1'b0, "R1 locked", int'(locked), 0);
        chk(bit_valid == 1'b0, "R1 bit_valid", int'(bit_valid), 0);
        chk(rclk == 1'b0, "R1 rclk", int'(rclk), 0);

        // R2: edges while off
        vn = 0;
        for (int i = 0; i < 8; i++) begin
            rx_line = ~rx_line;
            repeat (3) @(negedge clk);
        end
        chk(locked == 1'b0, "R2 no lock while off", int'(locked), 0);
        chk(vn == 0, "R2 no strobe while off", vn, 0);

        // R3: hunt waits for an edge
        search_cmd = 1'b1;
        @(negedge clk);
        search_cmd = 1'b0;
        repeat (3) @(negedge clk);
        chk(locked == 1'b0, "R3 quiet hunt", int'(locked), 0);

        // R4 table walk
        vn = 0;
        cfirst = 0;
        for (int i = 0; i < NV; i++) begin
            drive_cell(VEC[i][5], int'(VEC[i][4:0]), c);
            if (i == 0) cfirst = c;
        end
        repeat (16) @(negedge clk);
        chk(locked == 1'b1, "R8 one empty window keeps lock", int'(locked), 1);
        repeat (16) @(negedge clk);
        chk(locked == 1'b0, "R8 two empty windows drop lock", int'(locked), 0);
        chk(vn == NV + 1, "R4 strobe count", vn, NV + 1);
        chk(vcyc[0] - cfirst == 15, "R5 first strobe", vcyc[0] - cfirst, 15);
        for (int i = 0; i < NV; i++)
            chk(vbit[i] == VEC[i][5], "R4 decoded bit", int'(vbit[i]), int'(VEC[i][5]));
        chk(vbit[NV] == 1'b1, "R4 quiet cell reads 1", int'(vbit[NV]), 1);

        adj_run(16, 15, 16, "R5 nominal spacing");
        adj_run(14, 14, 16, "R6 early boundary");
        adj_run(18, 15, 17, "R6 late boundary");
        adj_run(17, 15, 16, "R7 one late no adjust");
        adj_run(15, 15, 16, "R7 one early no adjust");

        // R3/R11 lock and recovered clock
        arm();
        rx_line = ~rx_line;
        @(negedge clk);
        chk(locked == 1'b1, "R3 lock on first edge", int'(locked), 1);
        chk(rclk == 1'b1, "R11 first half high", int'(rclk), 1);
        repeat (8) @(negedge clk);
        chk(rclk == 1'b0, "R11 second half low", int'(rclk), 0);

        // R10 rehunt
        search_cmd = 1'b1;
        @(negedge clk);
        search_cmd = 1'b0;
        chk(locked == 1'b0, "R10 search drops lock", int'(locked), 0);
        rx_line = ~rx_line;
        @(negedge clk);
        chk(locked == 1'b1, "R10 relock", int'(locked), 1);

        // R9 priority
        disable_cmd = 1'b1;
        search_cmd = 1'b1;
        @(negedge clk);
        disable_cmd = 1'b0;
        search_cmd = 1'b0;
        chk(locked == 1'b0, "R9 disable wins", int'(locked), 0);
        cnt_before = vn;
        for (int i = 0; i < 6; i++) begin
            rx_line = ~rx_line;
            repeat (4) @(negedge clk);
        end
        chk(locked == 1'b0, "R9 stays off", int'(locked), 0);
        chk(vn == cnt_before, "R9 no strobe after disable", vn, cnt_before);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule